// File: doc/BRIEF.md
# Rounding Integer Accumulator Cut

This unit extracts a 32-bit signed word from a 64-bit signed accumulator. A signed cut-point operand picks the window. Conceptually the accumulator is sign-extended to 128 bits, and the result's most significant bit is taken from position (63 - cut) of that extended value. Every bit below the window is discarded. The first discarded bit rounds the word to nearest, and any value outside the signed 32-bit range is clamped to the nearest limit.

A negative cut point first moves the accumulator further right by an arithmetic shift. After that shift the window is handled as if the cut were zero. An upstream issue stage presents the accumulator, the cut point and a single-cycle strobe together. The clamped word and a matching valid flag appear one clock later. Writing the accumulator back and reporting saturation status belong to other units.

Top module: `acc_cut_round`

## Requirements
- R1: `cut_in` is a 7-bit two's complement number in the range -64 to +63. For example, 7'h7F means -1, 7'h40 means -64 and 7'h3F means +63.
- R2: For a negative cut c, the accumulator is first shifted arithmetically right by -c, or by 63 when c is -64. Processing then continues with the cut taken as 0.
- R3: For a cut c from 0 to 31, the unrounded word is the accumulator shifted arithmetically right by 32 - c.
- R4: On that path, one is added to the unrounded word when accumulator bit (31 - c) is set and the unrounded word is signed-less-than 0x7FFFFFFF. At exactly 0x7FFFFFFF no increment happens.
- R5: For a cut c from 32 to 63, the word is the accumulator shifted left by c - 32. The range-check value is the accumulator shifted arithmetically right by 63 - c. On the R3 path, the range-check value is the rounded word shifted arithmetically right by 31.
- R6: A range-check value below -1 gives 0x80000000. A value above 0 gives 0x7FFFFFFF. Any other value passes the low 32 bits of the word through unchanged.
- R7: When `in_vld` is high at a rising clock edge, `out_vld` is high after that edge and `res_out` holds the result for the inputs sampled at that edge.
- R8: When `in_vld` is low at an edge, `out_vld` is low after it, and `res_out` keeps its previous value whatever `acc_in` and `cut_in` carry.
- R9: A synchronous reset (`rst` high at an edge) clears `out_vld` and `res_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand strobe |
| acc_in | input | 64 | Signed accumulator value |
| cut_in | input | 7 | Signed cut point |
| out_vld | output | 1 | Result valid, one cycle after the strobe |
| res_out | output | 32 | Rounded and clamped signed result |

## Verification
The bench aims at the boundary where the unrounded word already equals positive full scale. A design that rounded there unconditionally would wrap to 0x80000000 or flag a false overflow. Another target is the -64 cut, where a design that shifted by 64 instead of 63 would lose the sign of negative accumulators. Negative half-way values such as -2^31 at cut 0 must round up to zero and not to -1, which exposes a wrong round-bit index. Cuts of 31, 32 and 63 exercise the switch between the two range-check formulas, where a swapped formula saturates values that fit or lets through values that overflow.

// File: rtl/acut_pkg.sv
package acut_pkg;

    localparam int ACUT_ACC_W = 64;
    localparam int ACUT_CUT_W = 7;
    localparam int ACUT_RES_W = 32;

    typedef enum logic [1:0] {
        CLS_PASS = 2'd0,
        CLS_HIGH = 2'd1,
        CLS_LOW  = 2'd2
    } sat_cls_e;

endpackage

// File: rtl/acut_prenorm.sv
module acut_prenorm #(
    parameter int ACC_W = 64,
    parameter int CUT_W = 7
) (
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic        [CUT_W-1:0] cut_i,
    output logic signed [ACC_W-1:0] acc_o,
    output logic        [CUT_W-2:0] cut_o
);
    localparam int IW = $clog2(ACC_W);
    localparam logic [CUT_W:0] SH_LIM = (CUT_W+1)'(ACC_W - 1);

    logic            neg;
    logic [CUT_W:0]  mag;
    logic [IW-1:0]   sh;

    always_comb begin
        neg = cut_i[CUT_W-1];
        // magnitude of a negative cut, one bit wider so -min fits
        mag = (CUT_W+1)'(0) - {cut_i[CUT_W-1], cut_i};
        // a magnitude reaching the word width collapses to a sign fill
        sh  = (mag > SH_LIM) ? IW'(ACC_W - 1) : IW'(mag);
        acc_o = neg ? (acc_i >>> sh) : acc_i;
        cut_o = neg ? '0 : cut_i[CUT_W-2:0];
    end

endmodule

// File: rtl/acut_shift.sv
module acut_shift #(
    parameter int ACC_W = 64,
    parameter int RES_W = 32,
    parameter int CW    = 6
) (
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic        [CW-1:0]    cut_i,
    output logic signed [ACC_W-1:0] low_o,
    output logic signed [ACC_W-1:0] chk_o
);
    localparam int IW = $clog2(ACC_W);
    localparam logic [IW-1:0] RW_I  = IW'(RES_W);
    localparam logic [IW-1:0] RW_M1 = IW'(RES_W - 1);
    localparam logic [IW-1:0] AW_M1 = IW'(ACC_W - 1);
    localparam logic signed [ACC_W-1:0] FS_POS =
        {{(ACC_W-RES_W+1){1'b0}}, {(RES_W-1){1'b1}}};

    logic [IW-1:0]            cut_x;
    logic                     narrow;
    logic [IW-1:0]            rsh;
    logic [IW-1:0]            rbit;
    logic [IW-1:0]            lsh;
    logic [IW-1:0]            csh;
    logic signed [ACC_W-1:0]  pre;
    logic                     rnd;
    logic signed [ACC_W-1:0]  rounded;

    always_comb begin
        cut_x  = IW'(cut_i);
        narrow = (cut_x < RW_I);
        rsh    = RW_I - cut_x;
        rbit   = RW_M1 - cut_x;
        lsh    = cut_x - RW_I;
        csh    = AW_M1 - cut_x;

        // narrow window: drop low bits, round on the first dropped bit
        pre     = acc_i >>> rsh;
        rnd     = acc_i[rbit] && (pre < FS_POS);
        rounded = pre + {{(ACC_W-1){1'b0}}, rnd};

        if (narrow) begin
            low_o = rounded;
            chk_o = rounded >>> (RES_W - 1);
        end else begin
            low_o = acc_i <<< lsh;
            chk_o = acc_i >>> csh;
        end
    end

endmodule

// File: rtl/acut_sat.sv
module acut_sat
    import acut_pkg::*;
#(
    parameter int ACC_W = 64,
    parameter int RES_W = 32
) (
    input  logic signed [ACC_W-1:0] low_i,
    input  logic signed [ACC_W-1:0] chk_i,
    output logic        [RES_W-1:0] res_o,
    output sat_cls_e                cls_o
);
    localparam logic signed [ACC_W-1:0] M_ONE = '1;
    localparam logic signed [ACC_W-1:0] ZERO  = '0;
    localparam logic [RES_W-1:0] LIM_HI = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] LIM_LO = {1'b1, {(RES_W-1){1'b0}}};

    always_comb begin
        if (chk_i < M_ONE) begin
            cls_o = CLS_LOW;
        end else if (chk_i > ZERO) begin
            cls_o = CLS_HIGH;
        end else begin
            cls_o = CLS_PASS;
        end

        unique case (cls_o)
            CLS_HIGH: res_o = LIM_HI;
            CLS_LOW:  res_o = LIM_LO;
            default:  res_o = low_i[RES_W-1:0];
        endcase
    end

endmodule

// File: rtl/acc_cut_round.sv
module acc_cut_round
    import acut_pkg::*;
#(
    parameter int ACC_W = ACUT_ACC_W,
    parameter int CUT_W = ACUT_CUT_W,
    parameter int RES_W = ACUT_RES_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [CUT_W-1:0] cut_in,
    output logic             out_vld,
    output logic [RES_W-1:0] res_out
);
    localparam int CW = CUT_W - 1;
    localparam logic [RES_W-1:0] LIM_HI = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] LIM_LO = {1'b1, {(RES_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] M_ONE = '1;
    localparam logic signed [ACC_W-1:0] ZERO  = '0;

    typedef struct packed {
        logic             vld;
        logic [RES_W-1:0] res;
    } stage_t;

    logic signed [ACC_W-1:0] acc_s;
    logic signed [ACC_W-1:0] norm_acc;
    logic        [CW-1:0]    norm_cut;
    logic signed [ACC_W-1:0] low_w;
    logic signed [ACC_W-1:0] chk_w;
    logic        [RES_W-1:0] sat_res;
    sat_cls_e                sat_cls;

    stage_t stage_d;
    stage_t stage_q;

    assign acc_s = $signed(acc_in);

    acut_prenorm #(.ACC_W(ACC_W), .CUT_W(CUT_W)) u_prenorm (
        .acc_i (acc_s),
        .cut_i (cut_in),
        .acc_o (norm_acc),
        .cut_o (norm_cut)
    );

    acut_shift #(.ACC_W(ACC_W), .RES_W(RES_W), .CW(CW)) u_shift (
        .acc_i (norm_acc),
        .cut_i (norm_cut),
        .low_o (low_w),
        .chk_o (chk_w)
    );

    acut_sat #(.ACC_W(ACC_W), .RES_W(RES_W)) u_sat (
        .low_i (low_w),
        .chk_i (chk_w),
        .res_o (sat_res),
        .cls_o (sat_cls)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_vld;
        if (in_vld) begin
            stage_d.res = sat_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_vld = stage_q.vld;
    assign res_out = stage_q.res;

    // strobe shows up as a valid result one edge later
    assert_strobe_lat_R7: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    // idle cycles leave the result register untouched
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && $stable(res_out)));

    // a positive range-check value must land as the upper limit
    assert_clamp_hi_R6: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (chk_w > ZERO)) |=> (res_out == LIM_HI));

    // a range-check value below -1 must land as the lower limit
    assert_clamp_lo_R6: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (chk_w < M_ONE)) |=> (res_out == LIM_LO));

    // a negative cut reaches the window logic as a zero cut
    assert_negcut_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (in_vld && cut_in[CUT_W-1]) |-> (norm_cut == '0));

    // the classifier and the result mux agree on pass-through words
    assert_pass_low_R6: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (sat_cls == CLS_PASS)) |=> (res_out == $past(low_w[RES_W-1:0])));

endmodule

// File: tb/acc_cut_round_tb.sv
module acc_cut_round_tb;

    localparam int NV = 18;

    // accumulator, cut, expected result
    localparam logic [63:0] T_ACC [NV] = '{
        64'h0000_0001_0000_0000,   // R3 plain shift
        64'h0000_0000_8000_0000,   // R4 half rounds up
        64'hFFFF_FFFF_8000_0000,   // R4 negative half rounds to zero
        64'h0000_7FFF_FFFF_FFFF,   // R4 carry into bit 15
        64'h7FFF_FFFF_8000_0000,   // R4 no round at positive full scale
        64'h0000_0001_0000_0000,   // R6 overflow at cut 31
        64'hFFFF_FFFF_0000_0000,   // R6 exact minimum passes at cut 31
        64'hFFFF_FFFF_0000_0000,   // R5 R6 underflow at cut 32
        64'h0000_0000_0000_0005,   // R5 cut 32 passes small value
        64'h0000_0000_0000_0001,   // R5 overflow at cut 63
        64'hFFFF_FFFF_FFFF_FFFF,   // R5 minus one at cut 63
        64'h0000_0003_0000_0000,   // R2 cut -1
        64'h8000_0000_0000_0000,   // R2 cut -64 negative
        64'h7FFF_FFFF_FFFF_FFFF,   // R2 cut -64 positive
        64'h4000_0000_0000_0000,   // R1 7'h7F is -1 not +63
        64'h0000_0000_1234_8000,   // R3 R4 cut 16
        64'hC000_0000_0000_0000,   // R6 underflow at cut 2
        64'h0000_0000_0000_1234    // R5 cut 48
    };
    localparam logic [6:0] T_CUT [NV] = '{
        7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h1F, 7'h1F, 7'h20, 7'h20,
        7'h3F, 7'h3F, 7'h7F, 7'h40, 7'h40, 7'h7F, 7'h10, 7'h02, 7'h30
    };
    localparam logic [31:0] T_EXP [NV] = '{
        32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 32'h0000_8000,
        32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0000,
        32'h0000_0005, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0002,
        32'h0000_0000, 32'h0000_0000, 32'h2000_0000, 32'h0000_1235,
        32'h8000_0000, 32'h1234_0000
    };

    logic        clk;
    logic        rst;
    logic        in_vld;
    logic [63:0] acc_in;
    logic [6:0]  cut_in;
    logic        out_vld;
    logic [31:0] res_out;

    int checks;
    int errors;
    bit done;

    acc_cut_round u_dut (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .acc_in  (acc_in),
        .cut_in  (cut_in),
        .out_vld (out_vld),
        .res_out (res_out)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // model written from R1..R6
    function automatic logic [31:0] model(input logic [63:0] a, input logic [6:0] c);
        longint acc;
        longint lo;
        longint up;
        int     ci;
        acc = longint'(a);
        ci  = int'($signed(c));
        if (ci < 0) begin
            acc = (ci == -64) ? (acc >>> 63) : (acc >>> (-ci));
            ci  = 0;
        end
        if (ci < 32) begin
            lo = acc >>> (32 - ci);
            if ((lo < 64'sh7FFF_FFFF) && acc[31 - ci]) lo = lo + 1;
            up = lo >>> 31;
        end else begin
            lo = acc << (ci - 32);
            up = acc >>> (63 - ci);
        end
        if (up < -1) return 32'h8000_0000;
        if (up > 0)  return 32'h7FFF_FFFF;
        return lo[31:0];
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [63:0] a, input logic [6:0] c,
                           input logic [31:0] exp, input string tag);
        @(negedge clk);
        acc_in = a;
        cut_in = c;
        in_vld = 1'b1;
        @(negedge clk);
        check({31'd0, out_vld}, 32'd1, {tag, " R7 valid"});
        check(res_out, exp, tag);
    endtask

    initial begin
        checks = 0;
        errors = 0;
        done   = 1'b0;
        rst    = 1'b1;
        in_vld = 1'b0;
        acc_in = '0;
        cut_in = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check({31'd0, out_vld}, 32'd0, "R9 reset valid");
        check(res_out, 32'd0, "R9 reset result");
        rst = 1'b0;

        // vector table, back to back strobes
        for (int i = 0; i < NV; i++) begin
            run_vec(T_ACC[i], T_CUT[i], T_EXP[i], $sformatf("R6 table %0d", i));
        end

        // R8: idle cycle with changed operands holds the last word
        @(negedge clk);
        in_vld = 1'b0;
        acc_in = 64'h0123_4567_89AB_CDEF;
        cut_in = 7'h05;
        @(negedge clk);
        check({31'd0, out_vld}, 32'd0, "R8 idle valid");
        check(res_out, T_EXP[NV-1], "R8 idle hold");
        @(negedge clk);
        check(res_out, T_EXP[NV-1], "R8 idle hold second cycle");

        // sweep against the model
        begin
            logic [63:0] lf;
            lf = 64'hACE1_2468_9BDF_1357;
            for (int k = 0; k < 400; k++) begin
                logic [63:0] a;
                logic [6:0]  c;
                lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
                a  = $signed(lf) >>> lf[13:8];
                c  = lf[22:16];
                run_vec(a, c, model(a, c), "R3 R4 R5 sweep");
            end
        end

        // R4 boundary: one below full scale still rounds
        run_vec(64'h7FFF_FFFE_8000_0000, 7'h00, 32'h7FFF_FFFF, "R4 round to full scale");

        // R9 mid-run reset
        run_vec(64'h0000_0000_0000_0007, 7'h20, 32'h0000_0007, "R5 pre-reset");
        @(negedge clk);
        in_vld = 1'b1;
        rst    = 1'b1;
        @(negedge clk);
        check({31'd0, out_vld}, 32'd0, "R9 mid reset valid");
        check(res_out, 32'd0, "R9 mid reset result");
        rst    = 1'b0;
        in_vld = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule